// File: doc/BRIEF.md
# Pseudo-Associative Cache Controller

This block is a single-ported cache controller. On the first look-up it acts like a direct-mapped cache. When that look-up misses, it makes a second look-up in a partner frame, which is the frame whose index differs only in its top bit. The two frames form a pseudo-set. A hit in the partner frame takes one cycle longer than a normal hit and is flagged separately. The controller then exchanges the two frames, so the block just used sits in its home frame for the next access.

Tags, valid bits and data live in internal register arrays. Writes go through to the next memory level. A write that misses installs nothing. When both look-ups miss a read, the controller fetches a full block over a simple request/response port. The fetched block goes into the home frame. The home frame's previous valid occupant moves into the partner frame, and the partner frame's previous block is dropped. Three saturating counters tally fast hits, slow hits and misses.

Top module: `pseudo_assoc_cache`

## Requirements
- R1: Addresses count words. With the default parameters, cpuAddr[1:0] selects the word within a 4-word block, cpuAddr[4:2] is the home index, and cpuAddr[9:5] is the tag. A read hit returns the word at that offset.
- R2: After reset every frame is invalid. cpuReady is 1, and respValid, memReq, fastHit and slowHit are 0. All three counters read 0.
- R3: A read that hits its home frame raises respValid and fastHit in the first cycle after the request is accepted, with the correct data. It makes no request to the next level.
- R4: A read that misses its home frame but hits the partner frame raises respValid and slowHit in the second cycle after acceptance, with the correct data. It makes no request to the next level.
- R5: The partner frame index is the home index with its top bit inverted. A block is identified by its tag together with its own home-index top bit, so two blocks that share a tag and differ only in that bit are never confused.
- R6: After a slow hit the two frames of the pseudo-set are exchanged. The next access to the same block is a fast hit, and an access to the block that was displaced is a slow hit.
- R7: A read that misses both frames issues memReq with memWe=0 and a block-aligned memAddr. When memValid arrives, respValid is raised with the requested word from memRdata. The block is placed in its home frame. If the home frame held a valid block, that block moves to the partner frame and the partner's former block is evicted. If the home frame was empty, the partner frame is left as it was.
- R8: Every write issues memReq with memWe=1, memAddr equal to the request address and memWdata equal to the write data. respValid is raised when memValid arrives. A write that hits (fast or slow) also updates the cached word, and a slow write hit exchanges the frames as in R6.
- R9: A write that misses both frames installs nothing, so a later read of that block is a miss. The miss is counted.
- R10: fastCnt, slowCnt and missCnt are 16-bit counters. Each adds one per fast hit, slow hit or double miss, and each holds at 16'hFFFF once it gets there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpuReq | input | 1 | Request valid; accepted when cpuReady is 1 |
| cpuWe | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | ADDR_W | Word address |
| cpuWdata | input | DATA_W | Write data |
| cpuReady | output | 1 | Controller is idle and can accept a request |
| respValid | output | 1 | Request complete; read data valid |
| cpuRdata | output | DATA_W | Read data |
| fastHit | output | 1 | Home-frame hit in this cycle |
| slowHit | output | 1 | Partner-frame hit in this cycle |
| memReq | output | 1 | Next-level request, held until memValid |
| memWe | output | 1 | Next-level request is a write |
| memAddr | output | ADDR_W | Word address for a write, block-aligned address for a fetch |
| memWdata | output | DATA_W | Next-level write data |
| memValid | input | 1 | Next level has completed the request |
| memRdata | input | WORDS*DATA_W | Fetched block, word 0 in the low bits |
| fastCnt | output | CNT_W | Fast-hit count |
| slowCnt | output | CNT_W | Slow-hit count |
| missCnt | output | CNT_W | Miss count |

## Verification
A corrupted tag, or a tag stored without its index top bit, would surface on the very next access to the affected block. That access would get the wrong hit class, a request to the next level where none was due, or wrong read data from a block that shares its tag. A missed exchange after a slow hit would show as a second slow hit, one cycle too long, on the repeat access. A wrong eviction on a fill would show only when the displaced block is touched again, as a miss instead of a slow hit. The directed sequences therefore revisit every moved block right away.

// File: rtl/pac_pkg.sv
package pac_pkg;

  typedef enum logic [1:0] {
    RD_PRI = 2'd0,
    RD_ALT = 2'd1,
    RD_MEM = 2'd2
  } rd_sel_e;

  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_PROBE1 = 3'd1,
    S_PROBE2 = 3'd2,
    S_FILL   = 3'd3,
    S_WRITE  = 3'd4
  } pac_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    capture;
    logic    wrPri;
    logic    swap;
    logic    fill;
    rd_sel_e rdSel;
    logic    incFast;
    logic    incSlow;
    logic    incMiss;
  } pac_strobe_t;

endpackage

// File: rtl/pac_satcnt.sv
module pac_satcnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else if (inc && cnt != TOP) cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/pac_ctrl.sv
module pac_ctrl
  import pac_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        cpuReq,
  input  logic        reqWe,
  input  logic        priHit,
  input  logic        altHit,
  input  logic        memValid,
  output pac_strobe_t st,
  output logic        cpuReady,
  output logic        respValid,
  output logic        fastHit,
  output logic        slowHit,
  output logic        memReq,
  output logic        memWe
);
  pac_state_e state, stateNxt;

  always_ff @(posedge clk) begin
    if (rst) state <= S_IDLE;
    else     state <= stateNxt;
  end

  always_comb begin
    st        = '0;
    st.rdSel  = RD_PRI;
    stateNxt  = state;
    cpuReady  = 1'b0;
    respValid = 1'b0;
    fastHit   = 1'b0;
    slowHit   = 1'b0;
    memReq    = 1'b0;
    memWe     = 1'b0;
    unique case (state)
      S_IDLE: begin
        cpuReady = 1'b1;
        if (cpuReq) begin
          st.capture = 1'b1;
          stateNxt   = S_PROBE1;
        end
      end
      S_PROBE1: begin
        if (priHit) begin
          fastHit    = 1'b1;
          st.incFast = 1'b1;
          if (reqWe) begin
            st.wrPri = 1'b1;
            stateNxt = S_WRITE;
          end else begin
            respValid = 1'b1;
            st.rdSel  = RD_PRI;
            stateNxt  = S_IDLE;
          end
        end else begin
          stateNxt = S_PROBE2;
        end
      end
      S_PROBE2: begin
        if (altHit) begin
          slowHit    = 1'b1;
          st.incSlow = 1'b1;
          st.swap    = 1'b1;
          if (reqWe) begin
            st.wrPri = 1'b1;
            stateNxt = S_WRITE;
          end else begin
            respValid = 1'b1;
            st.rdSel  = RD_ALT;
            stateNxt  = S_IDLE;
          end
        end else begin
          st.incMiss = 1'b1;
          stateNxt   = reqWe ? S_WRITE : S_FILL;
        end
      end
      S_FILL: begin
        memReq   = 1'b1;
        st.rdSel = RD_MEM;
        if (memValid) begin
          st.fill   = 1'b1;
          respValid = 1'b1;
          stateNxt  = S_IDLE;
        end
      end
      S_WRITE: begin
        memReq = 1'b1;
        memWe  = 1'b1;
        if (memValid) begin
          respValid = 1'b1;
          stateNxt  = S_IDLE;
        end
      end
      default: stateNxt = S_IDLE;
    endcase
  end
endmodule

// File: rtl/pac_datapath.sv
module pac_datapath
  import pac_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int FRAMES = 8,
  parameter int WORDS  = 4,
  parameter int CNT_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  pac_strobe_t             st,
  input  logic                    cpuWe,
  input  logic [ADDR_W-1:0]       cpuAddr,
  input  logic [DATA_W-1:0]       cpuWdata,
  input  logic [WORDS*DATA_W-1:0] memRdata,
  output logic                    priHit,
  output logic                    altHit,
  output logic                    reqWe,
  output logic [DATA_W-1:0]       cpuRdata,
  output logic [ADDR_W-1:0]       memAddr,
  output logic [DATA_W-1:0]       memWdata,
  output logic [CNT_W-1:0]        fastCnt,
  output logic [CNT_W-1:0]        slowCnt,
  output logic [CNT_W-1:0]        missCnt
);
  localparam int OFF_W = $clog2(WORDS);
  localparam int IDX_W = $clog2(FRAMES);
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W;
  localparam int KEY_W = TAG_W + 1;
  localparam int BLK_W = WORDS * DATA_W;
  localparam logic [IDX_W-1:0] TOP_BIT = IDX_W'(1) << (IDX_W - 1);

  logic [ADDR_W-1:0] reqAddr;
  logic [DATA_W-1:0] reqWdata;
  logic [OFF_W-1:0]  reqOff;
  logic [IDX_W-1:0]  priIdx, altIdx;
  logic [KEY_W-1:0]  reqKey;

  logic [KEY_W-1:0]  tagArr  [FRAMES];
  logic [BLK_W-1:0]  dataArr [FRAMES];
  logic [FRAMES-1:0] validArr;
  logic [BLK_W-1:0]  wrBlk;

  assign reqOff = reqAddr[OFF_W-1:0];
  assign priIdx = reqAddr[OFF_W +: IDX_W];
  assign altIdx = priIdx ^ TOP_BIT;
  // tag plus the home-index top bit identifies the block in either frame
  assign reqKey = {reqAddr[ADDR_W-1 -: TAG_W], priIdx[IDX_W-1]};

  assign priHit = validArr[priIdx] && (tagArr[priIdx] == reqKey);
  assign altHit = validArr[altIdx] && (tagArr[altIdx] == reqKey);

  always_comb begin
    wrBlk = st.swap ? dataArr[altIdx] : dataArr[priIdx];
    wrBlk[reqOff*DATA_W +: DATA_W] = reqWdata;
  end

  always_comb begin
    unique case (st.rdSel)
      RD_ALT:  cpuRdata = dataArr[altIdx][reqOff*DATA_W +: DATA_W];
      RD_MEM:  cpuRdata = memRdata[reqOff*DATA_W +: DATA_W];
      default: cpuRdata = dataArr[priIdx][reqOff*DATA_W +: DATA_W];
    endcase
  end

  assign memAddr  = reqWe ? reqAddr : {reqAddr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign memWdata = reqWdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      reqAddr  <= '0;
      reqWdata <= '0;
      reqWe    <= 1'b0;
    end else if (st.capture) begin
      reqAddr  <= cpuAddr;
      reqWdata <= cpuWdata;
      reqWe    <= cpuWe;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      validArr <= '0;
      for (int f = 0; f < FRAMES; f++) begin
        tagArr[f]  <= '0;
        dataArr[f] <= '0;
      end
    end else if (st.fill) begin
      tagArr[priIdx]   <= reqKey;
      dataArr[priIdx]  <= memRdata;
      validArr[priIdx] <= 1'b1;
      if (validArr[priIdx]) begin
        tagArr[altIdx]   <= tagArr[priIdx];
        dataArr[altIdx]  <= dataArr[priIdx];
        validArr[altIdx] <= 1'b1;
      end
    end else if (st.swap) begin
      tagArr[priIdx]  <= tagArr[altIdx];
      tagArr[altIdx]  <= tagArr[priIdx];
      dataArr[priIdx] <= st.wrPri ? wrBlk : dataArr[altIdx];
      dataArr[altIdx] <= dataArr[priIdx];
    end else if (st.wrPri) begin
      dataArr[priIdx] <= wrBlk;
    end
  end

  // event counters: fast, slow, miss
  logic [2:0]       incVec;
  logic [CNT_W-1:0] cntArr [3];
  assign incVec = {st.incMiss, st.incSlow, st.incFast};

  for (genvar c = 0; c < 3; c++) begin : g_cnt
    pac_satcnt #(.W(CNT_W)) u_cnt (
      .clk (clk),
      .rst (rst),
      .inc (incVec[c]),
      .cnt (cntArr[c])
    );
  end

  assign fastCnt = cntArr[0];
  assign slowCnt = cntArr[1];
  assign missCnt = cntArr[2];
endmodule

// File: rtl/pseudo_assoc_cache.sv
module pseudo_assoc_cache
  import pac_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int FRAMES = 8,
  parameter int WORDS  = 4,
  parameter int CNT_W  = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cpuReq,
  input  logic                    cpuWe,
  input  logic [ADDR_W-1:0]       cpuAddr,
  input  logic [DATA_W-1:0]       cpuWdata,
  output logic                    cpuReady,
  output logic                    respValid,
  output logic [DATA_W-1:0]       cpuRdata,
  output logic                    fastHit,
  output logic                    slowHit,
  output logic                    memReq,
  output logic                    memWe,
  output logic [ADDR_W-1:0]       memAddr,
  output logic [DATA_W-1:0]       memWdata,
  input  logic                    memValid,
  input  logic [WORDS*DATA_W-1:0] memRdata,
  output logic [CNT_W-1:0]        fastCnt,
  output logic [CNT_W-1:0]        slowCnt,
  output logic [CNT_W-1:0]        missCnt
);
  pac_strobe_t st;
  logic priHit, altHit, reqWe;

  pac_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cpuReq    (cpuReq),
    .reqWe     (reqWe),
    .priHit    (priHit),
    .altHit    (altHit),
    .memValid  (memValid),
    .st        (st),
    .cpuReady  (cpuReady),
    .respValid (respValid),
    .fastHit   (fastHit),
    .slowHit   (slowHit),
    .memReq    (memReq),
    .memWe     (memWe)
  );

  pac_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .FRAMES (FRAMES),
    .WORDS  (WORDS),
    .CNT_W  (CNT_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .st       (st),
    .cpuWe    (cpuWe),
    .cpuAddr  (cpuAddr),
    .cpuWdata (cpuWdata),
    .memRdata (memRdata),
    .priHit   (priHit),
    .altHit   (altHit),
    .reqWe    (reqWe),
    .cpuRdata (cpuRdata),
    .memAddr  (memAddr),
    .memWdata (memWdata),
    .fastCnt  (fastCnt),
    .slowCnt  (slowCnt),
    .missCnt  (missCnt)
  );
endmodule

// File: rtl/pac_chk.sv
module pac_chk #(
  parameter int ADDR_W = 10,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              cpuReq,
  input logic              cpuReady,
  input logic              fastHit,
  input logic              slowHit,
  input logic              memReq,
  input logic              memWe,
  input logic              memValid,
  input logic [ADDR_W-1:0] memAddr,
  input logic [CNT_W-1:0]  fastCnt,
  input logic [CNT_W-1:0]  slowCnt
);
  // R3
  fast_latency_chk: assert property (@(posedge clk) disable iff (rst)
    fastHit |-> $past(cpuReq && cpuReady));

  // R4
  slow_latency_chk: assert property (@(posedge clk) disable iff (rst)
    slowHit |-> $past(cpuReq && cpuReady, 2));

  // R7
  mem_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (memReq && !memValid) |=> (memReq && $stable(memAddr) && $stable(memWe)));

  // R10
  fast_count_chk: assert property (@(posedge clk) disable iff (rst)
    fastHit |=> ((fastCnt == $past(fastCnt) + CNT_W'(1)) ||
                 ($past(fastCnt) == {CNT_W{1'b1}})));

  // R10
  slow_count_chk: assert property (@(posedge clk) disable iff (rst)
    slowHit |=> ((slowCnt == $past(slowCnt) + CNT_W'(1)) ||
                 ($past(slowCnt) == {CNT_W{1'b1}})));

  // R2
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (cpuReq && cpuReady) |=> !cpuReady);
endmodule

bind pseudo_assoc_cache pac_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cpuReq   (cpuReq),
  .cpuReady (cpuReady),
  .fastHit  (fastHit),
  .slowHit  (slowHit),
  .memReq   (memReq),
  .memWe    (memWe),
  .memValid (memValid),
  .memAddr  (memAddr),
  .fastCnt  (fastCnt),
  .slowCnt  (slowCnt)
);

// File: tb/pseudo_assoc_cache_test.sv
`timescale 1ns/1ps
module pseudo_assoc_cache_test;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;
  localparam int WORDS  = 4;
  localparam int CNT_W  = 16;
  localparam int LAT    = 3;
  localparam int KIND_FAST = 0, KIND_SLOW = 1, KIND_MISS = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpuReq = 1'b0, cpuWe = 1'b0;
  logic [ADDR_W-1:0] cpuAddr = '0;
  logic [DATA_W-1:0] cpuWdata = '0;
  logic cpuReady, respValid, fastHit, slowHit, memReq, memWe;
  logic [DATA_W-1:0] cpuRdata, memWdata;
  logic [ADDR_W-1:0] memAddr;
  logic memValid = 1'b0;
  logic [WORDS*DATA_W-1:0] memRdata = '0;
  logic [CNT_W-1:0] fastCnt, slowCnt, missCnt;

  always #2 clk = ~clk;

  pseudo_assoc_cache uut (
    .clk(clk), .rst(rst), .cpuReq(cpuReq), .cpuWe(cpuWe), .cpuAddr(cpuAddr),
    .cpuWdata(cpuWdata), .cpuReady(cpuReady), .respValid(respValid),
    .cpuRdata(cpuRdata), .fastHit(fastHit), .slowHit(slowHit),
    .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memValid(memValid), .memRdata(memRdata), .fastCnt(fastCnt),
    .slowCnt(slowCnt), .missCnt(missCnt)
  );

  int vectors = 0, miscompares = 0;
  int expFast = 0, expSlow = 0, expMiss = 0;
  logic [DATA_W-1:0] mem [1 << ADDR_W];
  int memOps = 0;
  logic [ADDR_W-1:0] lastMemAddr = '0;
  logic lastMemWe = 1'b0;
  logic [DATA_W-1:0] lastMemWdata = '0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] mk(input int tag, input int idx, input int off);
    return {tag[4:0], idx[2:0], off[1:0]};
  endfunction

  // next-level model, driven 1 ns after each rising edge
  initial begin
    int waitCnt = 0;
    for (int i = 0; i < (1 << ADDR_W); i++) mem[i] = (i * 32'h01010101) ^ 32'hA5000000;
    forever begin
      @(posedge clk); #1;
      if (memValid) begin
        memValid = 1'b0;
      end else if (memReq) begin
        if (waitCnt == LAT - 1) begin
          waitCnt = 0;
          memOps++;
          lastMemAddr = memAddr;
          lastMemWe = memWe;
          lastMemWdata = memWdata;
          if (memWe) mem[memAddr] = memWdata;
          else for (int k = 0; k < WORDS; k++)
            memRdata[k*DATA_W +: DATA_W] = mem[int'(memAddr) + k];
          memValid = 1'b1;
        end else waitCnt++;
      end
    end
  end

  // issue one access and check hit class, latency, data and next-level traffic
  task automatic access(input string req, input logic we, input logic [ADDR_W-1:0] addr,
                        input logic [DATA_W-1:0] wdata, input int kind);
    int lat = 0, ops0;
    logic sawFast = 1'b0, sawSlow = 1'b0;
    logic [DATA_W-1:0] rd;
    ops0 = memOps;
    @(negedge clk);
    chk(req, "ready before request", 32'(cpuReady), 1);
    cpuReq = 1'b1; cpuWe = we; cpuAddr = addr; cpuWdata = wdata;
    @(negedge clk);
    cpuReq = 1'b0;
    lat = 1;
    while (1) begin
      sawFast |= fastHit;
      sawSlow |= slowHit;
      if (respValid || lat > 40) break;
      @(negedge clk);
      lat++;
    end
    rd = cpuRdata;
    chk(req, "fastHit seen", 32'(sawFast), 32'(kind == KIND_FAST));
    chk(req, "slowHit seen", 32'(sawSlow), 32'(kind == KIND_SLOW));
    if (kind == KIND_FAST) expFast++;
    else if (kind == KIND_SLOW) expSlow++;
    else expMiss++;
    if (we) begin
      chk(req, "write ops", 32'(memOps - ops0), 1);
      chk(req, "write memWe", 32'(lastMemWe), 1);
      chk(req, "write addr", 32'(lastMemAddr), 32'(addr));
      chk(req, "write data", lastMemWdata, wdata);
    end else begin
      chk(req, "read data", rd, mem[addr]);
      if (kind == KIND_MISS) begin
        chk(req, "fetch ops", 32'(memOps - ops0), 1);
        chk(req, "fetch memWe", 32'(lastMemWe), 0);
        chk(req, "fetch addr aligned", 32'(lastMemAddr), 32'({addr[ADDR_W-1:2], 2'b00}));
      end else begin
        chk(req, "no traffic", 32'(memOps - ops0), 0);
        chk(req, "latency", 32'(lat), (kind == KIND_FAST) ? 1 : 2);
      end
    end
  endtask

  task automatic checkCounters(input string req);
    @(negedge clk);
    chk(req, "fastCnt", 32'(fastCnt), 32'(expFast));
    chk(req, "slowCnt", 32'(slowCnt), 32'(expSlow));
    chk(req, "missCnt", 32'(missCnt), 32'(expMiss));
  endtask

  task automatic testReset();
    @(negedge clk);
    chk("R2", "cpuReady", 32'(cpuReady), 1);
    chk("R2", "respValid", 32'(respValid), 0);
    chk("R2", "memReq", 32'(memReq), 0);
    chk("R2", "fastHit", 32'(fastHit), 0);
    chk("R2", "slowHit", 32'(slowHit), 0);
    checkCounters("R2");
  endtask

  task automatic testFastAndPartner();
    access("R7 cold", 1'b0, mk(3,1,2), '0, KIND_MISS);
    access("R3 R1 word1", 1'b0, mk(3,1,1), '0, KIND_FAST);
    access("R1 word3", 1'b0, mk(3,1,3), '0, KIND_FAST);
    // same tag, index differs only in top bit: must not match
    access("R5 twin miss", 1'b0, mk(3,5,0), '0, KIND_MISS);
    access("R5 first kept", 1'b0, mk(3,1,0), '0, KIND_FAST);
    access("R5 twin fast", 1'b0, mk(3,5,2), '0, KIND_FAST);
  endtask

  task automatic testSwapEvict();
    access("R7 displace", 1'b0, mk(7,1,3), '0, KIND_MISS);
    access("R4 slow", 1'b0, mk(3,1,2), '0, KIND_SLOW);
    access("R6 after swap", 1'b0, mk(3,1,1), '0, KIND_FAST);
    access("R6 displaced", 1'b0, mk(7,1,0), '0, KIND_SLOW);
    access("R7 evicted", 1'b0, mk(3,5,1), '0, KIND_MISS);
    checkCounters("R10");
  endtask

  task automatic testWrites();
    // block (3,1) now in frame 1, (3,5) in frame 5
    access("R8 write fast", 1'b1, mk(3,1,2), 32'hDEADBEEF, KIND_FAST);
    access("R8 read back", 1'b0, mk(3,1,2), '0, KIND_FAST);
    access("R7 refill", 1'b0, mk(7,1,1), '0, KIND_MISS);
    access("R8 write slow", 1'b1, mk(3,1,0), 32'h12345678, KIND_SLOW);
    access("R8 R6 read new", 1'b0, mk(3,1,0), '0, KIND_FAST);
    access("R9 write miss", 1'b1, mk(9,2,1), 32'hCAFEF00D, KIND_MISS);
    access("R9 no allocate", 1'b0, mk(9,2,1), '0, KIND_MISS);
    checkCounters("R10");
  endtask

  task automatic testSaturation();
    for (int n = 0; n < 65540; n++) begin
      @(negedge clk);
      cpuReq = 1'b1; cpuWe = 1'b0; cpuAddr = mk(3,1,0);
      @(negedge clk);
      cpuReq = 1'b0;
    end
    expFast = 65535;
    checkCounters("R10 saturate");
  endtask

  initial begin
    int cyc = 0;
    while (cyc < 180000) begin
      @(posedge clk);
      cyc++;
    end
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    testReset();
    testFastAndPartner();
    testSwapEvict();
    testWrites();
    testSaturation();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule